// File: doc/BRIEF.md
# Bus Clock Mode Controller

This block decides how often the system bus advances. The bus runs either from the main clock divided by a selectable whole ratio, or from a slow sub clock. There are two sub-clock modes. In the first, the main oscillator keeps running. In the second, the main oscillator is shut down to save power. The block does not produce a derived clock. It produces a one-cycle enable pulse, `bclk_en`, in its own clock domain, and bus logic advances only on the cycles where that pulse is high. The sub clock enters as a tick that is already synchronised, `sub_tick`. The two oscillators report readiness through level flags, and the block reads those flags only. It never measures any wait time itself.

Software chooses a mode by writing a 4-bit mode code. Each write is checked against the oscillator flags. A write that would switch onto a clock that is not ready is dropped, and a sticky error flag records it. A ratio that is accepted takes effect only when the current bus period ends, so no period is ever cut short. Three events return the block to a safe divide-by-8 setting: reset, a stop request, and the main clock being stopped. Leaving the power-saving sub-clock mode works in two steps. The main oscillator is restarted first, and the block then waits for its ready flag before it moves to divide-by-8.

Top module: `bclk_mode_ctrl`

## Requirements
- R1: During and after reset, `mode_o` is 5 (divide-by-8), `err_o` is 0, `main_osc_stop` is 0, and `bclk_en` pulses once every 8 clock cycles.
- R2: Mode codes 0 to 9 select divide ratios 1, 2, 3, 4, 6, 8, 10, 12, 14 and 16, in that order. In a ratio-N mode, `bclk_en` is high for one cycle in every N cycles. For code 0 it is high on every cycle.
- R3: An accepted ratio change completes the period already in progress at the old ratio. The next period then uses the new ratio. No period between two pulses is shorter than the ratio in force when that period began.
- R4: Outside the power-saving mode, codes 0, 1, 4, 6, 7, 8 and 9 are accepted only while `main_stable` is 1. Codes 2, 3 and 5 are accepted regardless of `main_stable`.
- R5: Code 10 (sub clock, main running) and code 11 (sub clock, main stopped) are accepted only while `sub_stable` is 1. In either mode, `bclk_en` copies `sub_tick` one cycle later.
- R6: A rejected write, or any write of a code from 12 to 15, leaves the mode unchanged and sets `err_o`. `err_o` stays at 1 until `err_clr` or reset. If a rejected write and `err_clr` arrive in the same cycle, the write wins.
- R7: `main_osc_stop` rises one cycle after code 11 is committed. It stays at 0 in code 10 and in every main-clock mode.
- R8: While in code 11, a write of any code from 0 to 9 causes the following:
  - `main_osc_stop` drops on the next cycle.
  - The mode stays at 11 for as long as `main_stable` is 0.
  - Once `main_stable` is 1, the block moves to divide-by-8 (code 5) at the next sub-clock pulse, whatever ratio was written.
- R9: While `stop_req` is high:
  - `bclk_en` is 0, `main_osc_stop` is 1 and `mode_o` is 5.
  - Writes are ignored.
  - `err_o` keeps its value.
  
  After `stop_req` is released, divide-by-8 runs with its first pulse 8 cycles later.
- R10: `mode_o` reports the committed mode code. It changes only in the cycle of a `bclk_en` pulse, or when forced by a stop request or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode write strobe |
| wr_mode | input | 4 | Requested mode code (0-9 main ratios, 10 sub, 11 sub with main stopped) |
| err_clr | input | 1 | Clears the sticky error flag |
| stop_req | input | 1 | Stop request, level sensitive |
| main_stable | input | 1 | Main oscillator ready flag |
| sub_stable | input | 1 | Sub oscillator ready flag |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period, already synchronised |
| bclk_en | output | 1 | Bus clock enable pulse |
| main_osc_stop | output | 1 | Request to halt the main oscillator |
| mode_o | output | 4 | Committed mode code |
| err_o | output | 1 | Sticky flag for a rejected mode write |

## Verification
The hardest case to reach is the exit from the power-saving sub-clock mode. To get there, the stimulus must first reach a main mode and then move into the plain sub-clock mode. From there it enters the mode with the main oscillator stopped, and finally it writes a main ratio while `main_stable` is held low. Only at that point can the bench see `main_osc_stop` drop while the mode is still held. It then raises `main_stable` and checks that the block lands on divide-by-8 rather than the ratio that was written. A scoreboard of expected pulse spacings runs through every ratio, and it also covers writes made part-way through a period, so a shortened first period would show up as a mismatch.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  localparam int MODE_W  = 4;
  localparam int RATIO_W = 5;

  localparam logic [MODE_W-1:0] MD_DIV1  = 4'd0;
  localparam logic [MODE_W-1:0] MD_DIV8  = 4'd5;
  localparam logic [MODE_W-1:0] MD_SUB   = 4'd10;
  localparam logic [MODE_W-1:0] MD_SUBLP = 4'd11;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [MODE_W-1:0] m);
    case (m)
      4'd0:    ratio_of = 5'd1;
      4'd1:    ratio_of = 5'd2;
      4'd2:    ratio_of = 5'd3;
      4'd3:    ratio_of = 5'd4;
      4'd4:    ratio_of = 5'd6;
      4'd5:    ratio_of = 5'd8;
      4'd6:    ratio_of = 5'd10;
      4'd7:    ratio_of = 5'd12;
      4'd8:    ratio_of = 5'd14;
      4'd9:    ratio_of = 5'd16;
      default: ratio_of = 5'd8;
    endcase
  endfunction

  function automatic logic is_sub(input logic [MODE_W-1:0] m);
    is_sub = (m == MD_SUB) || (m == MD_SUBLP);
  endfunction

  function automatic logic is_legal(input logic [MODE_W-1:0] m);
    is_legal = (m <= MD_SUBLP);
  endfunction

  // main ratios that must wait for a settled main oscillator
  function automatic logic needs_main(input logic [MODE_W-1:0] m);
    needs_main = (m == 4'd0) || (m == 4'd1) || (m == 4'd4) || (m == 4'd6) ||
                 (m == 4'd7) || (m == 4'd8) || (m == 4'd9);
  endfunction

endpackage

// File: rtl/bclk_mode_guard.sv
module bclk_mode_guard
  import bclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              err_clr,
  input  logic              main_stable,
  input  logic              sub_stable,
  output logic [MODE_W-1:0] tgt_mode,
  output logic              wake_pend,
  output logic              err
);

  logic in_lp;
  logic reject;

  assign in_lp  = (tgt_mode == MD_SUBLP);
  assign reject = !is_legal(wr_mode) ||
                  (is_sub(wr_mode) && !sub_stable) ||
                  (!in_lp && needs_main(wr_mode) && !main_stable);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_mode  <= MD_DIV8;
      wake_pend <= 1'b0;
      err       <= 1'b0;
    end else if (stop_req) begin
      tgt_mode  <= MD_DIV8;
      wake_pend <= 1'b0;
      if (err_clr) err <= 1'b0;
    end else begin
      if (wr_en && reject)  err <= 1'b1;
      else if (err_clr)     err <= 1'b0;

      if (wr_en && !reject) begin
        if (in_lp && !is_sub(wr_mode)) begin
          wake_pend <= 1'b1;
        end else begin
          tgt_mode  <= wr_mode;
          wake_pend <= 1'b0;
        end
      end else if (wake_pend && main_stable) begin
        tgt_mode  <= MD_DIV8;
        wake_pend <= 1'b0;
      end
    end
  end

  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_req && wr_en && !is_legal(wr_mode) && !wake_pend) |=> (err && $stable(tgt_mode)));

  // R5
  sub_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_req && wr_en && is_sub(wr_mode) && !sub_stable && !wake_pend)
      |=> (err && $stable(tgt_mode)));

  // R4
  main_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_req && wr_en && needs_main(wr_mode) && !main_stable && !in_lp && !wake_pend)
      |=> (err && $stable(tgt_mode)));

  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_pend && !main_stable && !stop_req && !wr_en) |=> (wake_pend && $stable(tgt_mode)));

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
  import bclk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              sub_tick,
  input  logic [MODE_W-1:0] tgt_mode,
  output logic [MODE_W-1:0] cur_mode,
  output logic              bclk_en
);

  logic [CNT_W-1:0]   cnt;
  logic [RATIO_W-1:0] ratio;
  logic               on_sub;
  logic               term;

  assign ratio  = ratio_of(cur_mode);
  assign on_sub = is_sub(cur_mode);
  assign term   = on_sub ? sub_tick : (RATIO_W'(cnt) == ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst || stop_req) begin
      cnt      <= '0;
      cur_mode <= MD_DIV8;
      bclk_en  <= 1'b0;
    end else begin
      bclk_en <= term;
      if (term) begin
        cnt      <= '0;
        cur_mode <= tgt_mode;
      end else if (!on_sub) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R3
  commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!term && !stop_req) |=> $stable(cur_mode));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !on_sub |-> (RATIO_W'(cnt) < ratio));

  // R9
  stop_force_chk: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> (!bclk_en && cur_mode == MD_DIV8));

endmodule

// File: rtl/bclk_mode_ctrl.sv
module bclk_mode_ctrl
  import bclk_pkg::*;
#(
  parameter int MAX_RATIO = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              err_clr,
  input  logic              stop_req,
  input  logic              main_stable,
  input  logic              sub_stable,
  input  logic              sub_tick,
  output logic              bclk_en,
  output logic              main_osc_stop,
  output logic [MODE_W-1:0] mode_o,
  output logic              err_o
);

  localparam int CNT_W = $clog2(MAX_RATIO);

  logic [MODE_W-1:0] tgt_mode;
  logic [MODE_W-1:0] cur_mode;
  logic              wake_pend;

  bclk_mode_guard u_guard (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .wr_en       (wr_en),
    .wr_mode     (wr_mode),
    .err_clr     (err_clr),
    .main_stable (main_stable),
    .sub_stable  (sub_stable),
    .tgt_mode    (tgt_mode),
    .wake_pend   (wake_pend),
    .err         (err_o)
  );

  bclk_divider #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .sub_tick (sub_tick),
    .tgt_mode (tgt_mode),
    .cur_mode (cur_mode),
    .bclk_en  (bclk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) main_osc_stop <= 1'b0;
    else     main_osc_stop <= stop_req ||
                              (cur_mode == MD_SUBLP && tgt_mode == MD_SUBLP && !wake_pend);
  end

  assign mode_o = cur_mode;

  // R7
  osc_stop_src_chk: assert property (@(posedge clk) disable iff (rst)
    (main_osc_stop && !$past(stop_req)) |-> ($past(cur_mode) == MD_SUBLP));

  // R9
  stop_osc_chk: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> main_osc_stop);

endmodule

// File: tb/bclk_mode_ctrl_bench.sv
module bclk_mode_ctrl_bench;

  localparam int SUBP = 20;

  typedef struct {
    int gap;
    int req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_mode = 4'd0;
  logic       err_clr = 1'b0;
  logic       stop_req = 1'b0;
  logic       main_stable = 1'b0;
  logic       sub_stable = 1'b0;
  logic       sub_tick = 1'b0;
  logic       bclk_en;
  logic       main_osc_stop;
  logic [3:0] mode_o;
  logic       err_o;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t exp_q[$];
  bit   ended = 1'b0;

  bclk_mode_ctrl u_bclk_mode_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .err_clr(err_clr),
    .stop_req(stop_req), .main_stable(main_stable), .sub_stable(sub_stable),
    .sub_tick(sub_tick), .bclk_en(bclk_en), .main_osc_stop(main_osc_stop),
    .mode_o(mode_o), .err_o(err_o)
  );

  always #5 clk = ~clk;

  initial begin : sub_gen
    int sc;
    sc = 0;
    forever begin
      @(negedge clk);
      sub_tick <= (sc == SUBP - 1);
      sc = (sc + 1) % SUBP;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : monitor
    int gap;
    exp_t e;
    gap = 0;
    forever begin
      @(negedge clk);
      if (rst || stop_req) gap = 0;
      else begin
        gap++;
        if (bclk_en) begin
          if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            if (e.gap != 0)
              check(gap == e.gap, $sformatf("R%0d pulse spacing", e.req), gap, e.gap);
          end
          gap = 0;
        end
      end
    end
  end

  function automatic int ratio_exp(input logic [3:0] m);
    case (m)
      4'd0: return 1;   4'd1: return 2;   4'd2: return 3;   4'd3: return 4;
      4'd4: return 6;   4'd5: return 8;   4'd6: return 10;  4'd7: return 12;
      4'd8: return 14;  4'd9: return 16;  default: return SUBP;
    endcase
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic push(input int g, input int req);
    exp_t e;
    e.gap = g;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) tick(1);
  endtask

  task automatic write(input logic [3:0] m);
    wr_en = 1'b1;
    wr_mode = m;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic clear_err();
    err_clr = 1'b1;
    tick(1);
    err_clr = 1'b0;
  endtask

  // accepted main ratio change, issued right after a pulse
  task automatic main_step(input logic [3:0] old_m, input logic [3:0] new_m);
    int o, n;
    o = ratio_exp(old_m);
    n = ratio_exp(new_m);
    push(o, 3);
    if (o == 1) push(1, 3);
    for (int k = 0; k < 3; k++) push(n, 2);
    write(new_m);
    drain();
    check(mode_o == new_m, "R10 committed mode", mode_o, new_m);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(10 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : driver
    logic [3:0] seq [10];
    logic [3:0] prev;
    seq = '{4'd2, 4'd0, 4'd1, 4'd3, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9, 4'd5};

    tick(3);
    check(mode_o == 4'd5, "R1 reset mode", mode_o, 5);
    check(err_o == 1'b0, "R1 reset err", err_o, 0);
    check(main_osc_stop == 1'b0, "R1 reset osc stop", main_osc_stop, 0);
    check(bclk_en == 1'b0, "R1 reset enable", bclk_en, 0);
    push(0, 1);
    for (int k = 0; k < 3; k++) push(8, 1);
    rst = 1'b0;
    drain();

    main_stable = 1'b1;
    sub_stable = 1'b1;
    prev = 4'd5;
    for (int i = 0; i < 10; i++) begin
      main_step(prev, seq[i]);
      prev = seq[i];
    end

    // R3: write part-way into a divide-by-16 period
    main_step(4'd5, 4'd9);
    tick(5);
    push(16, 3);
    for (int k = 0; k < 3; k++) push(2, 3);
    write(4'd1);
    drain();
    check(mode_o == 4'd1, "R3 mid-period change mode", mode_o, 1);
    main_step(4'd1, 4'd5);

    // R4: guarded ratio rejected without main flag
    main_stable = 1'b0;
    for (int k = 0; k < 3; k++) push(8, 4);
    write(4'd1);
    drain();
    check(err_o == 1'b1, "R4 reject sets err", err_o, 1);
    check(mode_o == 4'd5, "R4 reject keeps mode", mode_o, 5);
    tick(4);
    check(err_o == 1'b1, "R6 err sticky", err_o, 1);
    clear_err();
    check(err_o == 1'b0, "R6 err cleared", err_o, 0);
    main_step(4'd5, 4'd3);
    check(err_o == 1'b0, "R4 unguarded ratio accepted", err_o, 0);
    main_step(4'd3, 4'd5);
    main_stable = 1'b1;

    // R6: reserved code
    for (int k = 0; k < 2; k++) push(8, 6);
    write(4'd13);
    drain();
    check(err_o == 1'b1, "R6 reserved code err", err_o, 1);
    check(mode_o == 4'd5, "R6 reserved code keeps mode", mode_o, 5);
    // R6: rejected write beats clear in the same cycle
    err_clr = 1'b1;
    write(4'd14);
    err_clr = 1'b0;
    check(err_o == 1'b1, "R6 write wins over clear", err_o, 1);
    clear_err();

    // R5: sub mode guarded by sub flag
    sub_stable = 1'b0;
    for (int k = 0; k < 2; k++) push(8, 5);
    write(4'd10);
    drain();
    check(err_o == 1'b1, "R5 sub reject err", err_o, 1);
    check(mode_o == 4'd5, "R5 sub reject keeps mode", mode_o, 5);
    clear_err();
    drain();
    sub_stable = 1'b1;
    push(8, 3);
    push(0, 5);
    for (int k = 0; k < 3; k++) push(SUBP, 5);
    write(4'd10);
    drain();
    check(mode_o == 4'd10, "R5 sub mode committed", mode_o, 10);
    check(main_osc_stop == 1'b0, "R7 sub run keeps main", main_osc_stop, 0);

    // R7: into sub mode with main stopped
    for (int k = 0; k < 3; k++) push(SUBP, 5);
    write(4'd11);
    drain();
    check(mode_o == 4'd11, "R7 low power committed", mode_o, 11);
    check(main_osc_stop == 1'b1, "R7 main stopped", main_osc_stop, 1);

    // R8: leave low power
    main_stable = 1'b0;
    push(SUBP, 8);
    push(SUBP, 8);
    write(4'd1);
    tick(1);
    check(main_osc_stop == 1'b0, "R8 main restarted", main_osc_stop, 0);
    check(err_o == 1'b0, "R8 no error on exit write", err_o, 0);
    drain();
    check(mode_o == 4'd11, "R8 held until main stable", mode_o, 11);
    main_stable = 1'b1;
    push(SUBP, 8);
    for (int k = 0; k < 3; k++) push(8, 8);
    drain();
    check(mode_o == 4'd5, "R8 returns to divide-by-8", mode_o, 5);

    // R9: stop request from divide-by-3
    main_step(4'd5, 4'd2);
    stop_req = 1'b1;
    tick(2);
    check(main_osc_stop == 1'b1, "R9 stop halts main", main_osc_stop, 1);
    check(mode_o == 4'd5, "R9 stop forces divide-by-8", mode_o, 5);
    write(4'd0);
    for (int k = 0; k < 6; k++) begin
      check(bclk_en == 1'b0, "R9 no enable in stop", bclk_en, 0);
      tick(1);
    end
    check(mode_o == 4'd5, "R9 write ignored in stop", mode_o, 5);
    check(err_o == 1'b0, "R9 err kept in stop", err_o, 0);
    stop_req = 1'b0;
    push(0, 9);
    for (int k = 0; k < 2; k++) push(8, 9);
    drain();
    check(mode_o == 4'd5, "R9 resumes divide-by-8", mode_o, 5);
    check(main_osc_stop == 1'b0, "R9 main released", main_osc_stop, 0);

    tick(4);
    finish_run();
  end

endmodule